// File: doc/BRIEF.md
# Dual-Frequency NCO Phase Core

This block is the digital heart of a direct digital synthesiser. On every clock it advances a 32-bit phase accumulator by one of two stored tuning words, so the generated frequency is the clock rate times the selected word divided by 2^32. The top 12 bits of the accumulator, plus one of four stored 12-bit phase offsets, form the address that a downstream sine table turns into an amplitude. The table and the converter after it lie outside this block.

The tuning words and offsets are loaded through a simple write port that carries a 3-bit destination code and 16 data bits. A frequency input picks the tuning word and a 2-bit phase input picks the offset. Both can be changed at any time without disturbing the accumulator. A clear control parks the accumulator at zero phase and keeps all loaded words. A sleep control freezes the accumulator and drops the valid flag.

Top module: `nco_dual_core`

## Requirements
- R1: On each clock edge with `clear` and `sleep` low, the accumulator grows by the selected tuning word modulo 2^32. Word 0 is used when `fsel` is 0 and word 1 when `fsel` is 1.
- R2: A write with `wr_sel` 0, 1, 2 or 3 loads `wr_data` into, in that order, the low half of word 0, the high half of word 0, the low half of word 1 and the high half of word 1. The other half of that word is left as it was.
- R3: A write with `wr_sel` 4, 5, 6 or 7 loads `wr_data[11:0]` into phase offset 0, 1, 2 or 3. Bits 15:12 of the data are ignored.
- R4: A tuning word written at one edge is first used by the accumulation at the next edge.
- R5: At each edge `phase_addr` takes the accumulator's top 12 bits as they stood before that edge, plus the offset chosen by `psel`, modulo 4096. Offset n is chosen when `psel` equals n.
- R6: Changing `fsel` changes only the step size. The accumulator keeps its value across the switch, so phase stays continuous.
- R7: While `clear` is high the accumulator is forced to zero and held there. Tuning words and offsets keep their contents, and accumulation resumes from zero once `clear` falls.
- R8: While `sleep` is high and `clear` is low the accumulator holds its value. The `phase_valid` output is low after any edge at which `sleep` was high.
- R9: While `rst_n` is low, all stored words, the accumulator, `phase_addr` and `phase_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_sel | input | 3 | Destination code of the write |
| wr_data | input | 16 | Write data |
| fsel | input | 1 | Tuning word select |
| psel | input | 2 | Phase offset select |
| clear | input | 1 | Force accumulator to zero phase and hold |
| sleep | input | 1 | Freeze accumulator and deassert valid |
| phase_addr | output | 12 | Phase address for the sine table |
| phase_valid | output | 1 | Phase address is live |

## Verification
A corrupted accumulator, a mis-steered half-word write or a wrong offset select all show up at `phase_addr` on the first edge after the fault reaches the top 12 bits. For offsets and upper half-words that happens at once. For low half-words it shows only after carries climb into bit 20, so the stimulus uses large low halves and long runs so that such errors surface within tens of cycles. Sleep and clear faults show either as a moving address that should be frozen or at zero, or as a valid flag that does not drop one edge after `sleep` rises.

// File: rtl/nco_pkg.sv
package nco_pkg;
    localparam int NUM_FREQ = 2;
    localparam int NUM_OFF  = 4;
    localparam int SEL_W    = 3;

    typedef enum logic [SEL_W-1:0] {
        WSEL_F0_LO  = 3'd0,
        WSEL_F0_HI  = 3'd1,
        WSEL_F1_LO  = 3'd2,
        WSEL_F1_HI  = 3'd3,
        WSEL_OFF0   = 3'd4,
        WSEL_OFF1   = 3'd5,
        WSEL_OFF2   = 3'd6,
        WSEL_OFF3   = 3'd7
    } wsel_e;
endpackage

// File: rtl/nco_tune_regs.sv
module nco_tune_regs
    import nco_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int PH_W  = 12,
    parameter int WR_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [WR_W-1:0]  wr_data,
    input  logic             fsel,
    input  logic [1:0]       psel,
    output logic [ACC_W-1:0] step_o,
    output logic [PH_W-1:0]  offset_o
);
    localparam int HALVES = ACC_W / WR_W;

    typedef struct packed {
        logic [NUM_FREQ-1:0][ACC_W-1:0] freq;
        logic [NUM_OFF-1:0][PH_W-1:0]   off;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int f = 0; f < NUM_FREQ; f++) begin
            for (int h = 0; h < HALVES; h++) begin
                if (wr_en && !wr_sel[2] && wr_sel[1] == 1'(f) && wr_sel[0] == 1'(h)) begin
                    st_d.freq[f][h*WR_W +: WR_W] = wr_data;
                end
            end
        end
        for (int p = 0; p < NUM_OFF; p++) begin
            if (wr_en && wr_sel[2] && wr_sel[1:0] == 2'(p)) begin
                st_d.off[p] = wr_data[PH_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign step_o   = st_q.freq[fsel];
    assign offset_o = st_q.off[psel];

    // R2: a low-half write leaves the high half untouched
    a_r2_half_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == WSEL_F0_LO) |=> $stable(st_q.freq[0][ACC_W-1:WR_W]));

    // R3: offset 0 takes only the low data bits
    a_r3_offset_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == WSEL_OFF0) |=> st_q.off[0] == $past(wr_data[PH_W-1:0]));
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] step_i,
    input  logic             clear,
    input  logic             sleep,
    output logic [ACC_W-1:0] acc_o
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_t;

    acc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear)       st_d.acc = '0;
        else if (!sleep) st_d.acc = st_q.acc + step_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o = st_q.acc;

    // R7: clear forces zero phase on the following edge
    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> st_q.acc == '0);

    // R8: sleep freezes the accumulator
    a_r8_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !clear) |=> $stable(st_q.acc));
endmodule

// File: rtl/nco_addr_gen.sv
module nco_addr_gen #(
    parameter int PH_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] acc_top_i,
    input  logic [PH_W-1:0] offset_i,
    input  logic            sleep,
    output logic [PH_W-1:0] addr_o,
    output logic            valid_o
);
    typedef struct packed {
        logic [PH_W-1:0] addr;
        logic            valid;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.addr  = acc_top_i + offset_i;
        st_d.valid = !sleep;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o  = st_q.addr;
    assign valid_o = st_q.valid;

    // R8: valid drops one edge after sleep
    a_r8_valid_low: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !valid_o);
endmodule

// File: rtl/nco_dual_core.sv
module nco_dual_core
    import nco_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int PH_W  = 12,
    parameter int WR_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [WR_W-1:0]  wr_data,
    input  logic             fsel,
    input  logic [1:0]       psel,
    input  logic             clear,
    input  logic             sleep,
    output logic [PH_W-1:0]  phase_addr,
    output logic             phase_valid
);
    logic [ACC_W-1:0] step_w;
    logic [PH_W-1:0]  offset_w;
    logic [ACC_W-1:0] acc_w;

    nco_tune_regs #(.ACC_W(ACC_W), .PH_W(PH_W), .WR_W(WR_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .fsel(fsel), .psel(psel),
        .step_o(step_w), .offset_o(offset_w)
    );

    nco_phase_acc #(.ACC_W(ACC_W)) i_acc (
        .clk(clk), .rst_n(rst_n), .step_i(step_w),
        .clear(clear), .sleep(sleep), .acc_o(acc_w)
    );

    nco_addr_gen #(.PH_W(PH_W)) i_addr (
        .clk(clk), .rst_n(rst_n), .acc_top_i(acc_w[ACC_W-1 -: PH_W]),
        .offset_i(offset_w), .sleep(sleep),
        .addr_o(phase_addr), .valid_o(phase_valid)
    );
endmodule

// File: tb/test_nco_dual_core.sv
`timescale 1ns/1ps
module test_nco_dual_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        fsel = 1'b0;
    logic [1:0]  psel = '0;
    logic        clear = 1'b0;
    logic        sleep = 1'b0;
    logic [11:0] phase_addr;
    logic        phase_valid;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R9";

    always #2 clk = ~clk;

    nco_dual_core i_nco_dual_core (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .fsel(fsel), .psel(psel), .clear(clear),
        .sleep(sleep), .phase_addr(phase_addr), .phase_valid(phase_valid)
    );

    // behavioural reference
    bit [31:0] m_acc;
    bit [31:0] m_f0, m_f1;
    bit [11:0] m_off [4];
    bit [11:0] m_addr;
    bit        m_valid;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_acc = 0; m_f0 = 0; m_f1 = 0; m_addr = 0; m_valid = 0;
            foreach (m_off[k]) m_off[k] = 0;
        end else begin
            m_addr  = m_acc[31:20] + m_off[psel];
            m_valid = !sleep;
            if (clear)       m_acc = 0;
            else if (!sleep) m_acc = m_acc + (fsel ? m_f1 : m_f0);
            if (wr_en) begin
                case (wr_sel)
                    3'd0: m_f0[15:0]  = wr_data;
                    3'd1: m_f0[31:16] = wr_data;
                    3'd2: m_f1[15:0]  = wr_data;
                    3'd3: m_f1[31:16] = wr_data;
                    default: m_off[wr_sel - 3'd4] = wr_data[11:0];
                endcase
            end
        end
    end

    task automatic compare();
        checks++;
        if (phase_addr !== m_addr || phase_valid !== m_valid) begin
            errors++;
            $display("FAIL %s: addr=%h valid=%b expected addr=%h valid=%b",
                     cur_req, phase_addr, phase_valid, m_addr, m_valid);
        end
    endtask

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            compare();
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        checks++;
        if (phase_addr !== 12'h0 || phase_valid !== 1'b0) begin
            errors++;
            $display("FAIL R9: addr=%h valid=%b expected addr=000 valid=0", phase_addr, phase_valid);
        end
        rst_n = 1'b1;
        cyc(2);

        // R3: offsets loaded under clear, upper data bits set
        cur_req = "R3";
        clear = 1'b1;
        wr(3'd4, 16'hF123);
        wr(3'd5, 16'hA456);
        wr(3'd6, 16'h5789);
        wr(3'd7, 16'hFFFF);
        for (int p = 0; p < 4; p++) begin
            psel = 2'(p);
            cyc(2);
        end

        // R2: half-word writes
        cur_req = "R2";
        wr(3'd0, 16'hFFFF);
        wr(3'd1, 16'h0100);
        wr(3'd2, 16'h8000);
        wr(3'd3, 16'h0030);
        clear = 1'b0;
        psel = 2'd0;
        cyc(40);
        wr(3'd1, 16'h0200);
        cyc(10);
        wr(3'd0, 16'h0001);
        cyc(30);

        // R4: update while running
        cur_req = "R4";
        wr(3'd1, 16'h0555);
        cyc(5);
        wr(3'd1, 16'h0010);
        cyc(5);

        // R6: frequency switching
        cur_req = "R6";
        for (int k = 0; k < 10; k++) begin
            fsel = ~fsel;
            cyc(3);
        end

        // R5: offset selection and wrap
        cur_req = "R5";
        wr(3'd7, 16'h0FF8);
        wr(3'd6, 16'h0800);
        for (int k = 0; k < 16; k++) begin
            psel = 2'(k);
            cyc(2);
        end

        // R8: sleep freezes and drops valid
        cur_req = "R8";
        sleep = 1'b1;
        for (int k = 0; k < 6; k++) begin
            fsel = ~fsel;
            cyc(2);
        end
        sleep = 1'b0;
        cyc(6);

        // R7: clear holds zero, registers survive
        cur_req = "R7";
        clear = 1'b1;
        psel = 2'd1;
        cyc(5);
        clear = 1'b0;
        cyc(20);

        // R1: large steps wrap the accumulator
        cur_req = "R1";
        wr(3'd3, 16'hF000);
        wr(3'd2, 16'h0000);
        fsel = 1'b1;
        psel = 2'd0;
        cyc(30);
        fsel = 1'b0;
        cyc(30);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule